// File: doc/BRIEF.md
# Register-Driven SPI Command Engine

This block is a small SPI master that a host drives through a byte-wide register bus with eight offsets. The host first fills the byte registers with an opcode, up to three address bytes and an optional data byte. It then writes a control byte that picks one of two serial clock rates, the number of reply bytes (zero to three) and a two-bit write-length code. The engine pulls chip select low and shifts the bytes out in SPI mode 0, most significant bit first. It then clocks in the reply bytes and stores them in registers the host can read back. A busy bit in the status register stays set until chip select has been released.

The write length is a code rather than a count, so only 1, 2, 4 and 5 bytes are possible. The address bytes are stored in reverse of the order in which they leave the wire. Both serial rates come from dividing the system clock, and the two divide ratios are parameters.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, chip select is high, SCLK and MOSI are low, the busy bit is clear, and every byte register at offsets 1 to 7 reads 0x00.
- R2: A write to offset 0 starts a transaction only when the engine is idle and data bits [7:4] are 0x4 or 0x5. Any other value of those bits leaves busy clear and chip select high.
- R3: Control bits [1:0] set the number of bytes sent, command byte included: 0 sends 1 byte, 1 sends 2, 2 sends 4 and 3 sends 5. The number of SCLK cycles in a transaction is 8 times the sum of bytes sent and bytes read.
- R4: The first byte on the wire is offset 1. For a 2-byte command the second byte is offset 7. For 4- and 5-byte commands, offsets 4, 3 and 2 follow in that order, and a 5-byte command ends with offset 7.
- R5: Control bits [3:2] give the reply byte count N (0 to 3). The reply bytes are stored in arrival order at offsets 5, 6 and 7, and an offset beyond N keeps its earlier value.
- R6: The wire uses SPI mode 0. SCLK is low while idle, bytes go out MSB first, MOSI changes only on falling SCLK edges, and MISO is sampled on rising edges.
- R7: With start code 0x4, each SCLK half period lasts SLOW_DIV system clocks, and with 0x5 it lasts FAST_DIV. The first rising edge comes one half period after the control write. The busy bit clears (2B+3) half periods after the control write, where B is the bit count of the transaction.
- R8: Chip select stays low from the control write until one half period after the last falling SCLK edge. It then stays high for two half periods before the busy bit clears.
- R9: A control write received while busy is ignored. It changes neither the bytes sent nor the timing of the running transaction.
- R10: Offset 0 reads as {busy, 7'b0}. Offsets 1 to 7 read back the last value written by the host or captured from the wire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
Every result of a transaction falls at a fixed point measured from the clock edge that captures the control write. With D the half period and B the bit count, SCLK is high during the odd half periods up to 2B, chip select rises after (2B+1)·D cycles, and busy falls after (2B+3)·D cycles. The bench computes these three levels for every cycle from that formula. It samples them on the falling system clock edge, after the registers have settled. Wire bytes and reply registers are checked only once busy has cleared, by a slave model that counts rising SCLK edges and by reads at each offset.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int          REG_OFFS = 8;
  localparam logic [2:0]  OFF_CTRL = 3'd0;
  localparam logic [2:0]  OFF_OPC  = 3'd1;
  localparam logic [2:0]  OFF_RX0  = 3'd5;

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_TAIL, ST_GAP} eng_state_t;

  // bytes on the wire for a write-length code
  function automatic logic [2:0] wlen_bytes(input logic [1:0] code);
    case (code)
      2'd0:    wlen_bytes = 3'd1;
      2'd1:    wlen_bytes = 3'd2;
      2'd2:    wlen_bytes = 3'd4;
      default: wlen_bytes = 3'd5;
    endcase
  endfunction

  // register offset feeding wire byte idx (address kept reversed in registers)
  function automatic logic [2:0] wslot(input logic [1:0] code, input logic [2:0] idx);
    case (idx)
      3'd0:    wslot = OFF_OPC;
      3'd1:    wslot = (code == 2'd1) ? 3'd7 : 3'd4;
      3'd2:    wslot = 3'd3;
      3'd3:    wslot = 3'd2;
      3'd4:    wslot = 3'd7;
      default: wslot = 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/spi_cmd_clkdiv.sv
module spi_cmd_clkdiv #(
  parameter int SLOW_DIV = 4,
  parameter int FAST_DIV = 2,
  parameter int DIV_W    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic fast,
  output logic tick
);
  localparam logic [DIV_W-1:0] SLOW_LIM = DIV_W'(SLOW_DIV - 1);
  localparam logic [DIV_W-1:0] FAST_LIM = DIV_W'(FAST_DIV - 1);
  localparam logic [DIV_W-1:0] ONE      = DIV_W'(1);

  logic [DIV_W-1:0] cnt_q, cnt_d, lim;

  assign lim  = fast ? FAST_LIM : SLOW_LIM;
  assign tick = run && (cnt_q == lim);

  always_comb begin
    if (!run)      cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_cmd_regbank.sv
module spi_cmd_regbank
  import spi_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  input  logic       cap_en,
  input  logic [2:0] cap_off,
  input  logic [7:0] cap_data,
  input  logic       busy,
  output logic [7:0] bank [REG_OFFS],
  output logic [7:0] rd_data
);
  assign bank[0] = 8'h00;

  for (genvar g = 1; g < REG_OFFS; g++) begin : g_slot
    logic [7:0] val_q, val_d;
    logic       cap_hit, host_hit;

    assign cap_hit  = cap_en && (cap_off == 3'(g));
    assign host_hit = wr_en && (addr == 3'(g));

    always_comb begin
      val_d = val_q;
      if (cap_hit)       val_d = cap_data;
      else if (host_hit) val_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) val_q <= 8'h00;
      else        val_q <= val_d;
    end

    assign bank[g] = val_q;
  end

  assign rd_data = (addr == OFF_CTRL) ? {busy, 7'b0} : bank[addr];
endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter
  import spi_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       start_fast,
  input  logic [1:0] start_wcode,
  input  logic [1:0] start_rcnt,
  input  logic       tick,
  input  logic       miso,
  input  logic [7:0] bank [REG_OFFS],
  output logic       busy,
  output logic       fast,
  output logic       sclk,
  output logic       mosi,
  output logic       cs_n,
  output logic       cap_en,
  output logic [2:0] cap_off,
  output logic [7:0] cap_data
);
  eng_state_t state_q, state_d;
  logic [1:0] code_q, code_d;
  logic [1:0] nr_q, nr_d;
  logic       fast_q, fast_d;
  logic [2:0] byte_q, byte_d;
  logic [2:0] bit_q, bit_d;
  logic [7:0] shreg_q, shreg_d;
  logic       rxbit_q, rxbit_d;
  logic       sclk_q, sclk_d;
  logic       cs_n_q, cs_n_d;
  logic       gap_q, gap_d;

  logic [2:0] nw;
  logic [3:0] tot, nxt;
  logic [7:0] done_byte;

  assign nw        = wlen_bytes(code_q);
  assign tot       = {1'b0, nw} + {2'b00, nr_q};
  assign nxt       = {1'b0, byte_q} + 4'd1;
  assign done_byte = {shreg_q[6:0], rxbit_q};

  always_comb begin
    state_d  = state_q;
    code_d   = code_q;
    nr_d     = nr_q;
    fast_d   = fast_q;
    byte_d   = byte_q;
    bit_d    = bit_q;
    shreg_d  = shreg_q;
    rxbit_d  = rxbit_q;
    sclk_d   = sclk_q;
    cs_n_d   = cs_n_q;
    gap_d    = gap_q;
    cap_en   = 1'b0;
    cap_off  = 3'd0;
    cap_data = 8'h00;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_SHIFT;
          code_d  = start_wcode;
          nr_d    = start_rcnt;
          fast_d  = start_fast;
          byte_d  = 3'd0;
          bit_d   = 3'd0;
          shreg_d = bank[OFF_OPC];
          sclk_d  = 1'b0;
          cs_n_d  = 1'b0;
          gap_d   = 1'b0;
        end
      end
      ST_SHIFT: begin
        if (tick) begin
          if (!sclk_q) begin
            sclk_d  = 1'b1;
            rxbit_d = miso;
          end else begin
            sclk_d = 1'b0;
            if (bit_q == 3'd7) begin
              if ({1'b0, byte_q} >= {1'b0, nw}) begin
                cap_en   = 1'b1;
                cap_off  = OFF_RX0 + (byte_q - nw);
                cap_data = done_byte;
              end
              if (nxt < tot) begin
                byte_d  = nxt[2:0];
                bit_d   = 3'd0;
                shreg_d = (nxt < {1'b0, nw}) ? bank[wslot(code_q, nxt[2:0])] : 8'h00;
              end else begin
                state_d = ST_TAIL;
                shreg_d = 8'h00;
              end
            end else begin
              shreg_d = done_byte;
              bit_d   = bit_q + 3'd1;
            end
          end
        end
      end
      ST_TAIL: begin
        if (tick) begin
          cs_n_d  = 1'b1;
          gap_d   = 1'b0;
          state_d = ST_GAP;
        end
      end
      default: begin
        if (tick) begin
          if (gap_q) state_d = ST_IDLE;
          else       gap_d   = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      code_q  <= 2'd0;
      nr_q    <= 2'd0;
      fast_q  <= 1'b0;
      byte_q  <= 3'd0;
      bit_q   <= 3'd0;
      shreg_q <= 8'h00;
      rxbit_q <= 1'b0;
      sclk_q  <= 1'b0;
      cs_n_q  <= 1'b1;
      gap_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      code_q  <= code_d;
      nr_q    <= nr_d;
      fast_q  <= fast_d;
      byte_q  <= byte_d;
      bit_q   <= bit_d;
      shreg_q <= shreg_d;
      rxbit_q <= rxbit_d;
      sclk_q  <= sclk_d;
      cs_n_q  <= cs_n_d;
      gap_q   <= gap_d;
    end
  end

  assign busy = (state_q != ST_IDLE);
  assign fast = fast_q;
  assign sclk = sclk_q;
  assign mosi = shreg_q[7];
  assign cs_n = cs_n_q;
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int SLOW_DIV = 4,
  parameter int FAST_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       spi_sclk,
  output logic       spi_cs_n,
  output logic       spi_mosi,
  input  logic       spi_miso
);
  localparam int DIV_W = $clog2(SLOW_DIV) + 1;

  logic [1:0] rsync_q;
  logic       rst_int_n;
  logic       eng_busy, eng_fast, tick, start;
  logic       cap_en;
  logic [2:0] cap_off;
  logic [7:0] cap_data;
  logic [7:0] bank [REG_OFFS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  // start codes 0x4 / 0x5 only, and only while idle
  assign start = reg_wr && (reg_addr == OFF_CTRL) && !eng_busy && (reg_wdata[7:5] == 3'b010);

  spi_cmd_clkdiv #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV), .DIV_W(DIV_W)) u_div (
    .clk (clk), .rst_n (rst_int_n), .run (eng_busy), .fast (eng_fast), .tick (tick)
  );

  spi_cmd_regbank u_bank (
    .clk (clk), .rst_n (rst_int_n), .wr_en (reg_wr), .addr (reg_addr), .wdata (reg_wdata),
    .cap_en (cap_en), .cap_off (cap_off), .cap_data (cap_data), .busy (eng_busy),
    .bank (bank), .rd_data (reg_rdata)
  );

  spi_cmd_shifter u_shf (
    .clk (clk), .rst_n (rst_int_n), .start (start), .start_fast (reg_wdata[4]),
    .start_wcode (reg_wdata[1:0]), .start_rcnt (reg_wdata[3:2]), .tick (tick),
    .miso (spi_miso), .bank (bank), .busy (eng_busy), .fast (eng_fast),
    .sclk (spi_sclk), .mosi (spi_mosi), .cs_n (spi_cs_n),
    .cap_en (cap_en), .cap_off (cap_off), .cap_data (cap_data)
  );
endmodule

// File: rtl/spi_cmd_chk.sv
module spi_cmd_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [2:0] addr,
  input logic [7:0] wdata,
  input logic       busy,
  input logic       sclk,
  input logic       mosi,
  input logic       cs_n
);
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk); // R6
  AST_MOSI_HOLD_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(mosi)); // R6
  AST_CS_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy); // R8
  AST_CS_HIGH_BEFORE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(cs_n)); // R8
  AST_START_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_en && (addr == 3'd0) && (wdata[7:5] == 3'b010))); // R2
  AST_CS_FALL_SCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> !sclk); // R6
endmodule

bind spi_cmd_engine spi_cmd_chk u_chk (
  .clk (clk), .rst_n (rst_n), .wr_en (reg_wr), .addr (reg_addr), .wdata (reg_wdata),
  .busy (eng_busy), .sclk (spi_sclk), .mosi (spi_mosi), .cs_n (spi_cs_n)
);

// File: tb/spi_cmd_engine_tb.sv
`timescale 1ns/1ps
module spi_cmd_engine_tb;
  localparam int SLOW_DIV = 4;
  localparam int FAST_DIV = 2;

  logic       clk;
  logic       rst_n;
  logic       reg_wr;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       spi_sclk, spi_cs_n, spi_mosi, spi_miso;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  logic [7:0]  host [8];
  logic [63:0] slave_stream;
  logic [63:0] rx_bits;
  int          rx_cnt;
  int          s_idx;

  spi_cmd_engine #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) u_dut (
    .clk (clk), .rst_n (rst_n), .reg_wr (reg_wr), .reg_addr (reg_addr),
    .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .spi_sclk (spi_sclk),
    .spi_cs_n (spi_cs_n), .spi_mosi (spi_mosi), .spi_miso (spi_miso)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // slave model: shifts MISO on falling SCLK, captures MOSI on rising SCLK
  assign spi_miso = (s_idx >= 0 && s_idx < 64) ? slave_stream[63 - s_idx] : 1'b0;
  always @(negedge spi_sclk) s_idx = s_idx + 1;
  always @(posedge spi_sclk) begin
    rx_bits = {rx_bits[62:0], spi_mosi};
    rx_cnt  = rx_cnt + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
    if (a != 3'd0) host[a] = d;
  endtask

  task automatic read_reg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic run_txn(input logic [7:0] ctrl, input bit poke, input logic [7:0] r0,
                         input logic [7:0] r1, input logic [7:0] r2);
    int code, nr, nw, d, nb, t_busy, t_cs, k, bad;
    logic [7:0] exp_w [5];
    logic [7:0] rsp [3];
    logic [7:0] rv;
    code = int'(ctrl[1:0]);
    nr   = int'(ctrl[3:2]);
    nw   = (code == 0) ? 1 : (code == 1) ? 2 : (code == 2) ? 4 : 5;
    d    = ctrl[4] ? FAST_DIV : SLOW_DIV;
    nb   = 8 * (nw + nr);
    t_busy = (2 * nb + 3) * d;
    t_cs   = (2 * nb + 1) * d;
    exp_w[0] = host[1];
    exp_w[1] = (code == 1) ? host[7] : host[4];
    exp_w[2] = host[3];
    exp_w[3] = host[2];
    exp_w[4] = host[7];
    rsp[0] = r0; rsp[1] = r1; rsp[2] = r2;
    slave_stream = '0;
    for (int r = 0; r < nr; r++) slave_stream[63 - 8 * (nw + r) -: 8] = rsp[r];
    @(negedge clk);
    s_idx = 0; rx_cnt = 0; rx_bits = '0;
    reg_addr = 3'd0; reg_wdata = ctrl; reg_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
    bad = 0;
    for (int j = 0; j <= t_busy + 3; j++) begin
      bit es, ecs, eb;
      if (poke && j == 5) begin reg_wr = 1'b1; reg_wdata = 8'h57; end
      if (poke && j == 6) reg_wr = 1'b0;
      k   = j / d;
      es  = (k % 2 == 1) && (k < 2 * nb);
      ecs = (j >= t_cs);
      eb  = (j < t_busy);
      if (bad == 0 && (spi_sclk !== es || spi_cs_n !== ecs || reg_rdata[7] !== eb)) begin
        bad = 1;
        $display("FAIL R7/R8 cycle %0d actual sclk/cs_n/busy=%0b%0b%0b expected=%0b%0b%0b",
                 j, spi_sclk, spi_cs_n, reg_rdata[7], es, ecs, eb);
      end
      @(posedge clk);
      @(negedge clk);
    end
    tests++;
    if (bad != 0) fails++;
    chk(poke ? "R9 bit count with busy write" : "R3 bit count", rx_cnt, nb);
    for (int i = 0; i < nw; i++)
      chk(poke ? "R9 wire byte" : "R4 wire byte", int'(rx_bits[nb - 1 - 8 * i -: 8]), int'(exp_w[i]));
    for (int r = 0; r < nr; r++) host[5 + r] = rsp[r];
    for (int a = 5; a < 8; a++) begin
      read_reg(3'(a), rv);
      chk("R5 reply register", int'(rv), int'(host[a]));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 3'd0; reg_wdata = 8'h00;
    s_idx = 0; rx_cnt = 0; rx_bits = '0; slave_stream = '0;
    for (int i = 0; i < 8; i++) host[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    chk("R1 cs_n", int'(spi_cs_n), 1);
    chk("R1 sclk", int'(spi_sclk), 0);
    chk("R1 mosi", int'(spi_mosi), 0);
    read_reg(3'd0, v); chk("R1 busy", int'(v), 0);
    for (int a = 1; a < 8; a++) begin
      read_reg(3'(a), v); chk("R1 register clear", int'(v), 0);
    end

    // R10 readback
    write_reg(3'd1, 8'hA5); write_reg(3'd2, 8'h12); write_reg(3'd3, 8'h34);
    write_reg(3'd4, 8'h56); write_reg(3'd5, 8'h99); write_reg(3'd6, 8'h66);
    write_reg(3'd7, 8'hC3);
    for (int a = 1; a < 8; a++) begin
      read_reg(3'(a), v); chk("R10 readback", int'(v), int'(host[a]));
    end

    // R2 non-start codes are ignored
    foreach (host[i]) ;
    begin
      logic [7:0] bad_codes [3];
      bad_codes[0] = 8'h35; bad_codes[1] = 8'h65; bad_codes[2] = 8'h00;
      for (int c = 0; c < 3; c++) begin
        int hit;
        write_reg(3'd0, bad_codes[c]);
        hit = 0;
        for (int j = 0; j < 20; j++) begin
          @(negedge clk);
          reg_addr = 3'd0;
          #1 if (reg_rdata[7] !== 1'b0 || spi_cs_n !== 1'b1) hit = 1;
        end
        chk("R2 ignored start code", hit, 0);
      end
    end

    // R3/R4/R5/R6/R7 various lengths, speeds and reply counts
    run_txn(8'h40, 1'b0, 8'h00, 8'h00, 8'h00);
    run_txn(8'h5D, 1'b0, 8'h3C, 8'h81, 8'hE7);
    run_txn(8'h46, 1'b0, 8'hB2, 8'h00, 8'h00);
    write_reg(3'd7, 8'h5A);
    // R9 control write during busy
    run_txn(8'h5B, 1'b1, 8'h0F, 8'hF0, 8'h00);
    write_reg(3'd1, 8'h0B); write_reg(3'd2, 8'h01); write_reg(3'd3, 8'h80);
    write_reg(3'd4, 8'hFE); write_reg(3'd7, 8'h77);
    run_txn(8'h4F, 1'b0, 8'h11, 8'h22, 8'h33);
    run_txn(8'h52, 1'b0, 8'h00, 8'h00, 8'h00);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule